// File: doc/BRIEF.md
# Vector-Sum Cavity Field Controller

This block holds the combined field of a string of superconducting cavities that share one RF power source. Each cavity delivers a demodulated field sample as a signed I/Q pair. Every channel is turned and scaled by its own complex coefficient, and the enabled channels are added into one complex vector sum. The block compares that sum with a complex setpoint and turns the error into a proportional-integral correction. It adds a feedforward value read from a table and writes one saturated I word and one Q word to the DAC that feeds the I/Q modulator.

The machine runs in pulses. A gate input is high for the whole RF pulse, and a second input marks the flat-top part of the pulse, where the beam is accelerated. The feedforward table is addressed by the number of samples since the gate rose. The integrator collects error only during the flat-top and starts every pulse from zero. While the gate is low the DAC words are zero. A sticky flag records any clipping of the output. Only the sum is regulated: the block never controls a single cavity's field on its own.

Top module: `vsum_field_ctrl`

## Requirements
- R1: While reset is held and after it is released, dac_i, dac_q and clip_flag are zero until a gated sample reaches the output.
- R2: Channel k gives rot_i = floor((c_re*x_i - c_im*x_q) / 2^14) and rot_q = floor((c_re*x_q + c_im*x_i) / 2^14). The coefficients are signed 16-bit values with 14 fraction bits, taken from coef_re/coef_im bits [16k+15:16k]. The sample comes from adc_i/adc_q bits [16k+15:16k]. The vector sum is the sum of rot over the channels.
- R3: A channel whose ch_en bit k is 0 adds nothing to the vector sum, whatever its sample and coefficient are.
- R4: The error is err = setpoint - vector sum, for I and Q separately. A sample taken at clock edge n shows at the outputs after edge n+1 as floor((kp*err + ki*integ) / 2^8) + ff, with the same kp and ki used for I and Q.
- R5: The integrator adds the sample's error, before it is used for that same sample's output, only when both pulse_gate and flat_top are high. A gated sample outside the flat-top leaves the integrator unchanged.
- R6: A sample with pulse_gate low clears the integrator, so every pulse starts its integral from zero.
- R7: The feedforward entry used is the count of gated samples since pulse_gate rose. The first gated sample uses entry 0, and the count stops at the last entry. A cycle with ff_we high writes ff_wdata_i/ff_wdata_q into entry ff_waddr.
- R8: Each output word is limited to the range -32768 to 32767.
- R9: clip_flag goes high after any gated sample whose I or Q value had to be limited, and stays high until reset.
- R10: An ungated sample gives dac_i = dac_q = 0 two edges later, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_gate | input | 1 | High for the whole RF pulse |
| flat_top | input | 1 | High during the flat-top section |
| ch_en | input | 12 | Per-channel enable |
| adc_i | input | 192 | Packed channel I samples, 16 bits each |
| adc_q | input | 192 | Packed channel Q samples, 16 bits each |
| coef_re | input | 192 | Packed coefficient real parts, Q2.14 |
| coef_im | input | 192 | Packed coefficient imaginary parts, Q2.14 |
| sp_i | input | 16 | Setpoint I |
| sp_q | input | 16 | Setpoint Q |
| kp | input | 16 | Signed proportional gain, 8 fraction bits |
| ki | input | 16 | Signed integral gain, 8 fraction bits |
| ff_we | input | 1 | Feedforward table write strobe |
| ff_waddr | input | 11 | Feedforward table write address |
| ff_wdata_i | input | 16 | Feedforward I value to write |
| ff_wdata_q | input | 16 | Feedforward Q value to write |
| dac_i | output | 16 | Modulator drive I word |
| dac_q | output | 16 | Modulator drive Q word |
| clip_flag | output | 1 | Sticky output-limit flag |

## Verification
The bench compares the outputs in every cycle with a model that works in full-width integers, so a rotation with the wrong sign, a floor replaced by truncation, or a pipeline one stage off shows up as a wrong sample. A pulse longer than the table checks that the index stops at the last entry; a wrapping index would read entry 0 again. Two pulses in a row with a flat-top window inside each check that the integral starts fresh; an integrator that is never cleared would carry the last pulse's offset into the next one. Driving both outputs past their rails checks the limiting and the sticky flag. Idle stretches with live inputs and flat_top toggling would expose any leak of drive outside the gate.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef logic signed [63:0] wide_t;

  // Real part of (c_re + j c_im) * (x_i + j x_q), shifted down with floor
  function automatic wide_t rot_re(wide_t xi, wide_t xq, wide_t cr, wide_t ci,
                                   int unsigned frac);
    return (cr * xi - ci * xq) >>> frac;
  endfunction

  // Imaginary part of the same product
  function automatic wide_t rot_im(wide_t xi, wide_t xq, wide_t cr, wide_t ci,
                                   int unsigned frac);
    return (cr * xq + ci * xi) >>> frac;
  endfunction

  // Proportional plus integral drive, fixed-point gains
  function automatic wide_t pi_drive(wide_t kp, wide_t err, wide_t ki,
                                     wide_t integ, int unsigned sh);
    return (kp * err + ki * integ) >>> sh;
  endfunction

  function automatic wide_t sat_hi(int unsigned w);
    return (64'sd1 <<< (w - 1)) - 64'sd1;
  endfunction

  function automatic logic sat_hit(wide_t v, int unsigned w);
    return (v > sat_hi(w)) || (v < (-sat_hi(w) - 64'sd1));
  endfunction

  function automatic wide_t sat_val(wide_t v, int unsigned w);
    wide_t hi;
    wide_t lo;
    hi = sat_hi(w);
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/vsc_chan_rot.sv
module vsc_chan_rot
  import vsc_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter int RW    = DW + CW + 1 - CFRAC
) (
  input  logic                 en,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] x_q,
  input  logic signed [CW-1:0] c_re,
  input  logic signed [CW-1:0] c_im,
  output logic signed [RW-1:0] r_i,
  output logic signed [RW-1:0] r_q
);

  wide_t prod_re;
  wide_t prod_im;

  always_comb begin
    prod_re = rot_re(64'(x_i), 64'(x_q), 64'(c_re), 64'(c_im), CFRAC);
    prod_im = rot_im(64'(x_i), 64'(x_q), 64'(c_re), 64'(c_im), CFRAC);
    r_i = en ? RW'(prod_re) : '0;
    r_q = en ? RW'(prod_im) : '0;
  end

endmodule

// File: rtl/vsc_ff_table.sv
module vsc_ff_table #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gate,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata_i,
  input  logic signed [DW-1:0] wdata_q,
  output logic [AW-1:0]        idx,
  output logic signed [DW-1:0] rd_i,
  output logic signed [DW-1:0] rd_q
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2*DW-1:0] mem [DEPTH];
  logic [AW-1:0]   cnt_q;

  // Sample index inside the pulse: zero on the first gated sample
  always_comb idx = gate ? cnt_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!gate)    cnt_q <= '0;
    else if (idx == LAST) cnt_q <= LAST;
    else               cnt_q <= idx + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wdata_q, wdata_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_i <= '0;
      rd_q <= '0;
    end else begin
      rd_i <= mem[idx][DW-1:0];
      rd_q <= mem[idx][2*DW-1:DW];
    end
  end

endmodule

// File: rtl/vsc_pi_stage.sv
module vsc_pi_stage
  import vsc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int GW  = 16,
  parameter int SW  = 23,
  parameter int EW  = SW + 1,
  parameter int IW  = EW + 13,
  parameter int KSH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gate_s1,
  input  logic                 flat_s1,
  input  logic signed [SW-1:0] vs_i,
  input  logic signed [SW-1:0] vs_q,
  input  logic signed [DW-1:0] sp_i,
  input  logic signed [DW-1:0] sp_q,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [DW-1:0] ff_i,
  input  logic signed [DW-1:0] ff_q,
  output logic signed [IW-1:0] integ_i,
  output logic signed [IW-1:0] integ_q,
  output logic                 sat_evt,
  output logic signed [DW-1:0] dac_i,
  output logic signed [DW-1:0] dac_q,
  output logic                 clip
);

  logic signed [EW-1:0] err_i, err_q;
  logic signed [IW-1:0] integ_nx_i, integ_nx_q;
  wide_t drv_i, drv_q;
  logic  hit_i, hit_q;

  always_comb begin
    err_i = EW'(sp_i) - EW'(vs_i);
    err_q = EW'(sp_q) - EW'(vs_q);
    if (!gate_s1) begin
      integ_nx_i = '0;
      integ_nx_q = '0;
    end else if (flat_s1) begin
      integ_nx_i = integ_i + IW'(err_i);
      integ_nx_q = integ_q + IW'(err_q);
    end else begin
      integ_nx_i = integ_i;
      integ_nx_q = integ_q;
    end
    drv_i = pi_drive(64'(kp), 64'(err_i), 64'(ki), 64'(integ_nx_i), KSH) + 64'(ff_i);
    drv_q = pi_drive(64'(kp), 64'(err_q), 64'(ki), 64'(integ_nx_q), KSH) + 64'(ff_q);
    hit_i = sat_hit(drv_i, DW);
    hit_q = sat_hit(drv_q, DW);
    sat_evt = gate_s1 && (hit_i || hit_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_i <= '0;
      integ_q <= '0;
      dac_i   <= '0;
      dac_q   <= '0;
      clip    <= 1'b0;
    end else begin
      integ_i <= integ_nx_i;
      integ_q <= integ_nx_q;
      dac_i   <= gate_s1 ? DW'(sat_val(drv_i, DW)) : '0;
      dac_q   <= gate_s1 ? DW'(sat_val(drv_q, DW)) : '0;
      clip    <= clip | sat_evt;
    end
  end

endmodule

// File: rtl/vsum_field_ctrl.sv
module vsum_field_ctrl #(
  parameter int NCH      = 12,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int CFRAC    = 14,
  parameter int GW       = 16,
  parameter int KSH      = 8,
  parameter int FF_DEPTH = 2048,
  localparam int AW      = $clog2(FF_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pulse_gate,
  input  logic                   flat_top,
  input  logic [NCH-1:0]         ch_en,
  input  logic [NCH*DW-1:0]      adc_i,
  input  logic [NCH*DW-1:0]      adc_q,
  input  logic [NCH*CW-1:0]      coef_re,
  input  logic [NCH*CW-1:0]      coef_im,
  input  logic signed [DW-1:0]   sp_i,
  input  logic signed [DW-1:0]   sp_q,
  input  logic signed [GW-1:0]   kp,
  input  logic signed [GW-1:0]   ki,
  input  logic                   ff_we,
  input  logic [AW-1:0]          ff_waddr,
  input  logic signed [DW-1:0]   ff_wdata_i,
  input  logic signed [DW-1:0]   ff_wdata_q,
  output logic signed [DW-1:0]   dac_i,
  output logic signed [DW-1:0]   dac_q,
  output logic                   clip_flag
);

  localparam int RW = DW + CW + 1 - CFRAC;
  localparam int SW = RW + $clog2(NCH);
  localparam int EW = SW + 1;
  localparam int IW = EW + AW + 2;

  logic signed [RW-1:0] rot_i [NCH];
  logic signed [RW-1:0] rot_q [NCH];
  logic signed [SW-1:0] sum_i, sum_q;
  logic signed [SW-1:0] vs_i, vs_q;
  logic                 gate_s1, flat_s1;
  logic [AW-1:0]        ff_idx;
  logic signed [DW-1:0] ff_i, ff_q;
  logic signed [IW-1:0] integ_i, integ_q;
  logic                 sat_evt;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    vsc_chan_rot #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .RW(RW)) u_rot (
      .en   (ch_en[k]),
      .x_i  (adc_i[k*DW +: DW]),
      .x_q  (adc_q[k*DW +: DW]),
      .c_re (coef_re[k*CW +: CW]),
      .c_im (coef_im[k*CW +: CW]),
      .r_i  (rot_i[k]),
      .r_q  (rot_q[k])
    );
  end

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < NCH; k++) begin
      sum_i = sum_i + SW'(rot_i[k]);
      sum_q = sum_q + SW'(rot_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_i    <= '0;
      vs_q    <= '0;
      gate_s1 <= 1'b0;
      flat_s1 <= 1'b0;
    end else begin
      vs_i    <= sum_i;
      vs_q    <= sum_q;
      gate_s1 <= pulse_gate;
      flat_s1 <= flat_top;
    end
  end

  vsc_ff_table #(.DW(DW), .DEPTH(FF_DEPTH), .AW(AW)) u_ff (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (pulse_gate),
    .we      (ff_we),
    .waddr   (ff_waddr),
    .wdata_i (ff_wdata_i),
    .wdata_q (ff_wdata_q),
    .idx     (ff_idx),
    .rd_i    (ff_i),
    .rd_q    (ff_q)
  );

  vsc_pi_stage #(.DW(DW), .GW(GW), .SW(SW), .EW(EW), .IW(IW), .KSH(KSH)) u_pi (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_s1 (gate_s1),
    .flat_s1 (flat_s1),
    .vs_i    (vs_i),
    .vs_q    (vs_q),
    .sp_i    (sp_i),
    .sp_q    (sp_q),
    .kp      (kp),
    .ki      (ki),
    .ff_i    (ff_i),
    .ff_q    (ff_q),
    .integ_i (integ_i),
    .integ_q (integ_q),
    .sat_evt (sat_evt),
    .dac_i   (dac_i),
    .dac_q   (dac_q),
    .clip    (clip_flag)
  );

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
  parameter int DW    = 16,
  parameter int AW    = 11,
  parameter int IW    = 37,
  parameter int DEPTH = 2048
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pulse_gate,
  input logic                 flat_top,
  input logic [AW-1:0]        ff_idx,
  input logic signed [IW-1:0] integ_i,
  input logic signed [IW-1:0] integ_q,
  input logic                 sat_evt,
  input logic signed [DW-1:0] dac_i,
  input logic signed [DW-1:0] dac_q,
  input logic                 clip_flag
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0] since_rst;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign armed = (since_rst == 2'd3);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(pulse_gate, 2)) |-> (dac_i == '0 && dac_q == '0)); // R10

  AST_INTEG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(pulse_gate, 2)) |-> (integ_i == '0 && integ_q == '0)); // R6

  AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pulse_gate, 2) && !$past(flat_top, 2)) |-> ($stable(integ_i) && $stable(integ_q))); // R5

  AST_IDX_START: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pulse_gate && !$past(pulse_gate)) |-> (ff_idx == '0)); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pulse_gate && $past(pulse_gate) && ($past(ff_idx) < LAST)) |-> (ff_idx == $past(ff_idx) + AW'(1))); // R7

  AST_IDX_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pulse_gate && $past(pulse_gate) && ($past(ff_idx) == LAST)) |-> (ff_idx == LAST)); // R7

  AST_CLIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> clip_flag); // R9

  AST_CLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    clip_flag |=> clip_flag); // R9

endmodule

bind vsum_field_ctrl vsc_checker #(.DW(DW), .AW(AW), .IW(IW), .DEPTH(FF_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulse_gate (pulse_gate),
  .flat_top   (flat_top),
  .ff_idx     (ff_idx),
  .integ_i    (integ_i),
  .integ_q    (integ_q),
  .sat_evt    (sat_evt),
  .dac_i      (dac_i),
  .dac_q      (dac_q),
  .clip_flag  (clip_flag)
);

// File: tb/sim_vsum_field_ctrl.sv
module sim_vsum_field_ctrl;

  localparam int NCH = 12;
  localparam int DW  = 16;
  localparam int DEP = 2048;
  localparam int AW  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_gate = 1'b0;
  logic flat_top = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH*DW-1:0] adc_i = '0, adc_q = '0, coef_re = '0, coef_im = '0;
  logic signed [DW-1:0] sp_i = '0, sp_q = '0, kp = '0, ki = '0;
  logic ff_we = 1'b0;
  logic [AW-1:0] ff_waddr = '0;
  logic signed [DW-1:0] ff_wdata_i = '0, ff_wdata_q = '0;
  logic signed [DW-1:0] dac_i, dac_q;
  logic clip_flag;

  always #5 clk = ~clk;

  vsum_field_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pulse_gate(pulse_gate), .flat_top(flat_top),
    .ch_en(ch_en), .adc_i(adc_i), .adc_q(adc_q), .coef_re(coef_re), .coef_im(coef_im),
    .sp_i(sp_i), .sp_q(sp_q), .kp(kp), .ki(ki), .ff_we(ff_we), .ff_waddr(ff_waddr),
    .ff_wdata_i(ff_wdata_i), .ff_wdata_q(ff_wdata_q),
    .dac_i(dac_i), .dac_q(dac_q), .clip_flag(clip_flag)
  );

  int checks = 0;
  int errors = 0;

  longint ffi [DEP];
  longint ffq [DEP];
  longint cre [NCH];
  longint cim [NCH];
  longint m_int_i, m_int_q;
  int     m_cnt;
  bit     m_clip;
  longint step_n;
  int     amp;

  longint p1_i, p1_q, p2_i, p2_q;
  string  p1_tag, p2_tag;
  bit     p1_v, p2_v;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint fdiv(longint v, int sh);
    longint d = longint'(1) << sh;
    longint q = v / d;
    if ((v % d != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint lim(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint smp(longint n, int ch, int q, int a);
    return (((n * 97 + ch * 131 + q * 57) * 7919) % (2 * a + 1)) - a;
  endfunction

  // One sample: check the output due now, then drive and model the next
  task automatic step(bit g, bit f, string tag);
    longint xi, xq, vsi, vsq, ei, eq, oi, oq;
    int idx;
    @(negedge clk);
    if (p2_v) begin
      chk(p2_tag, "dac_i", longint'(dac_i), p2_i);
      chk(p2_tag, "dac_q", longint'(dac_q), p2_q);
    end
    p2_v = p1_v; p2_i = p1_i; p2_q = p1_q; p2_tag = p1_tag;
    pulse_gate = g;
    flat_top = f;
    vsi = 0; vsq = 0;
    for (int c = 0; c < NCH; c++) begin
      xi = smp(step_n, c, 0, amp);
      xq = smp(step_n, c, 1, amp);
      adc_i[c*DW +: DW] = DW'(xi);
      adc_q[c*DW +: DW] = DW'(xq);
      if (ch_en[c]) begin
        vsi += fdiv(cre[c] * xi - cim[c] * xq, 14);
        vsq += fdiv(cre[c] * xq + cim[c] * xi, 14);
      end
    end
    step_n++;
    ei = longint'(sp_i) - vsi;
    eq = longint'(sp_q) - vsq;
    if (g && f) begin
      m_int_i += ei;
      m_int_q += eq;
    end
    idx = g ? m_cnt : 0;
    m_cnt = g ? ((m_cnt == DEP - 1) ? m_cnt : m_cnt + 1) : 0;
    if (g) begin
      oi = fdiv(longint'(kp) * ei + longint'(ki) * m_int_i, 8) + ffi[idx];
      oq = fdiv(longint'(kp) * eq + longint'(ki) * m_int_q, 8) + ffq[idx];
      if (lim(oi) != oi || lim(oq) != oq) m_clip = 1'b1;
      oi = lim(oi);
      oq = lim(oq);
    end else begin
      oi = 0; oq = 0;
      m_int_i = 0; m_int_q = 0;
    end
    p1_v = 1'b1; p1_i = oi; p1_q = oq; p1_tag = tag;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, k[1], "R10");
  endtask

  task automatic pulse(int len, int fon, int foff, string tag);
    for (int k = 0; k < len; k++) step(1'b1, (k >= fon) && (k < foff), tag);
    idle(6);
  endtask

  task automatic gains(int p, int i, int spi, int spq, int a);
    kp = DW'(p); ki = DW'(i); sp_i = DW'(spi); sp_q = DW'(spq); amp = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_int_i = 0; m_int_q = 0; m_cnt = 0; m_clip = 1'b0; step_n = 0; amp = 0;
    p1_v = 1'b0; p2_v = 1'b0; p1_i = 0; p1_q = 0; p2_i = 0; p2_q = 0;
    p1_tag = ""; p2_tag = "";
    for (int c = 0; c < NCH; c++) begin
      cre[c] = 16384 - c * 1100;
      cim[c] = c * 700 - 4000;
      coef_re[c*16 +: 16] = 16'(cre[c]);
      coef_im[c*16 +: 16] = 16'(cim[c]);
    end
    for (int k = 0; k < DEP; k++) begin
      ffi[k] = ((k * 37) % 2001) - 1000;
      ffq[k] = 500 - ((k * 13) % 1001);
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "dac_i in reset", longint'(dac_i), 0);
    chk("R1", "dac_q in reset", longint'(dac_q), 0);
    chk("R1", "clip in reset", longint'(clip_flag), 0);
    @(negedge clk) rst_n = 1'b1;

    // Fill the feedforward table (R7 write path)
    for (int k = 0; k < DEP; k++) begin
      @(negedge clk);
      ff_we = 1'b1;
      ff_waddr = AW'(k);
      ff_wdata_i = DW'(ffi[k]);
      ff_wdata_q = DW'(ffq[k]);
    end
    @(negedge clk) ff_we = 1'b0;
    chk("R1", "dac_i after reset", longint'(dac_i), 0);
    chk("R1", "clip after reset", longint'(clip_flag), 0);

    // R10: idle with live inputs
    ch_en = '1;
    gains(256, 0, 1000, -1000, 1000);
    idle(12);

    // R2: unity proportional gain, all channels, rotation sweep
    gains(256, 0, 0, 0, 1000);
    pulse(40, 99, 99, "R2");

    // R4: error against a nonzero setpoint
    gains(300, 0, 3000, -2500, 600);
    pulse(40, 99, 99, "R4");

    // R3: channel enables
    ch_en = 12'h0FF;
    gains(256, 0, 500, 700, 1000);
    pulse(30, 99, 99, "R3");
    ch_en = 12'h5A3;
    pulse(30, 99, 99, "R3");
    ch_en = '0;
    pulse(20, 99, 99, "R3");
    ch_en = '1;

    // R5 / R6: flat-top integration, two pulses in a row
    gains(128, 3, 2000, -1500, 800);
    pulse(60, 10, 50, "R5");
    pulse(60, 5, 40, "R6");

    // R7: pulse longer than the table, feedforward only
    gains(0, 0, 0, 0, 1000);
    pulse(DEP + 20, 0, DEP + 20, "R7");

    // R9: no clipping so far
    chk("R9", "clip before limit", longint'(clip_flag), longint'(m_clip));
    chk("R9", "clip still low", longint'(clip_flag), 0);

    // R8: drive both words past their rails
    gains(20000, 0, 30000, -30000, 500);
    pulse(20, 99, 99, "R8");
    chk("R9", "clip after limit", longint'(clip_flag), longint'(m_clip));
    chk("R9", "clip set", longint'(clip_flag), 1);

    // R9: flag stays set through a clean pulse
    gains(256, 0, 0, 0, 500);
    pulse(20, 99, 99, "R2");
    chk("R9", "clip sticky", longint'(clip_flag), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule